// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block runs the hardware side of entering an exception handler. An external arbiter hands it one chosen exception: its number and the address of its slot in the vector table. The sequencer then saves an eight-word context frame through a stack write port. At the same time it reads the handler start address through a separate instruction-side read port. When both are finished it emits a single-cycle update pulse. The pulse carries the new stack pointer, the handler address for the program counter, the exception number for the low status field and the special return code for the link register.

The frame goes to the process stack only when the interrupted code ran in thread mode on that stack. Otherwise it goes to the main stack, and the handler always runs on the main stack. The program counter and status words are written first. A higher-priority exception that arrives while words are still being written takes over the entry. The frame is left unchanged, and the vector is read again for the newcomer. An error response on a stack write aborts the sequence. It reports the fault with a status byte, where bit 4 marks the error in the bus-fault byte or, for a protection-unit error, in the memory-management byte.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_ready_o` is 1. `req_ready_o` is 0 from acceptance until the sequence ends, and requests presented meanwhile are ignored: the exception number of the running entry does not change.
- R2: After acceptance the block issues exactly eight stack writes, one per accepted beat (`sw_valid_o` and `sw_ready_i` both 1). Order and byte offsets from the frame base are: PC +0x18, PSR +0x1C, R0 +0x00, R1 +0x04, R2 +0x08, R3 +0x0C, R12 +0x10, LR +0x14. Data is the value present at acceptance, with `gpr_i` index 0..5 = R0,R1,R2,R3,R12,LR. Address and data stay stable while a beat waits for ready.
- R3: The frame base is the selected stack pointer minus 32. The process stack (`psp_i`) is selected when `psp_active_i`=1 and `handler_mode_i`=0, otherwise the main stack (`msp_i`). `upd_sp_o` gives the base and `upd_sp_psp_o` gives the selection (1 = process).
- R4: From the cycle after acceptance, a vector read at `req_vec_addr_i` is offered on the read port, concurrently with the writes. Read data is taken in the cycle where `vr_valid_o` and `vr_ready_i` are both 1, and becomes `upd_pc_o`.
- R5: `upd_valid_o` is a one-cycle pulse in the first cycle where all eight writes and the vector read are done. `req_ready_o` is 1 in the following cycle. With both ports always ready and no late arrival, a request accepted at clock edge n gives `upd_valid_o` high between edges n+8 and n+9.
- R6: At the pulse, `upd_num_o` is the exception number. `upd_lr_o` is 0xFFFFFFF1 if `handler_mode_i` was 1, 0xFFFFFFFD for thread mode on the process stack, and 0xFFFFFFF9 for thread mode on the main stack.
- R7: `late_valid_i` in a cycle where fewer than eight writes have been accepted (and no write error occurs) replaces the exception number with `late_num_i` and restarts the vector read at `late_vec_addr_i`. The frame is left unchanged. `late_valid_i` after the eighth write has no effect.
- R8: A write beat accepted with `sw_err_i`=1 ends the sequence in that cycle. `fault_o` is 1 in that same cycle, with 0x10 on `bf_status_o` if `sw_mpu_i`=0 or 0x10 on `mm_status_o` if `sw_mpu_i`=1, and the other byte 0. No further write follows, no update pulse is given, and `req_ready_o` is 1 in the next cycle.
- R9: After reset `req_ready_o` is 1, and `sw_valid_o`, `vr_valid_o`, `upd_valid_o` and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Entry request |
| req_ready_o | output | 1 | Sequencer idle, request taken |
| req_num_i | input | NUM_W | Exception number of the request |
| req_vec_addr_i | input | 32 | Vector table slot address |
| late_valid_i | input | 1 | Higher-priority late arrival |
| late_num_i | input | NUM_W | Late exception number |
| late_vec_addr_i | input | 32 | Late vector slot address |
| handler_mode_i | input | 1 | Interrupted code was a handler |
| psp_active_i | input | 1 | Interrupted code used the process stack |
| msp_i | input | 32 | Main stack pointer |
| psp_i | input | 32 | Process stack pointer |
| pc_i | input | 32 | Return PC to save |
| psr_i | input | 32 | Status word to save |
| gpr_i | input | 6x32 | R0,R1,R2,R3,R12,LR (index 0..5) |
| sw_valid_o | output | 1 | Stack write beat valid |
| sw_addr_o | output | 32 | Stack write address |
| sw_data_o | output | 32 | Stack write data |
| sw_ready_i | input | 1 | Stack write beat accepted |
| sw_err_i | input | 1 | Error response on accepted beat |
| sw_mpu_i | input | 1 | Error came from the protection unit |
| vr_valid_o | output | 1 | Vector read request |
| vr_addr_o | output | 32 | Vector read address |
| vr_ready_i | input | 1 | Vector read done, data valid |
| vr_rdata_i | input | 32 | Vector read data |
| upd_valid_o | output | 1 | Register update pulse |
| upd_num_o | output | NUM_W | New exception number field |
| upd_pc_o | output | 32 | Handler address |
| upd_sp_o | output | 32 | New stack pointer |
| upd_sp_psp_o | output | 1 | Updated pointer is the process stack |
| upd_lr_o | output | 32 | Return code for LR |
| fault_o | output | 1 | Stacking error pulse |
| bf_status_o | output | 8 | Bus fault status byte |
| mm_status_o | output | 8 | Memory management fault status byte |

## Verification
On every cycle, the assertions check the handshake and frame rules. Writes occur only while busy, always fall inside the 32-byte frame, start with the PC slot and hold steady under backpressure. They also check that the update pulse is single and returns the block to idle, that the return code is legal and matches the stack choice, and that a fault names exactly one status byte and leaves the block idle. Only the bench scenarios can show the exact write order and data, the captured context, the cycle count under zero wait, and that a late arrival retargets the number and vector while stacking is active but is ignored afterwards. The same holds for a request made while busy being dropped.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned FRAME_WORDS = 8;
  localparam int unsigned GPR_WORDS   = 6;
  localparam int unsigned FRAME_BYTES = FRAME_WORDS * (XLEN / 8);
  localparam int unsigned STK_ERR_BIT = 4;

  localparam logic [XLEN-1:0] RET_HANDLER = 32'hFFFF_FFF1;
  localparam logic [XLEN-1:0] RET_THR_MSP = 32'hFFFF_FFF9;
  localparam logic [XLEN-1:0] RET_THR_PSP = 32'hFFFF_FFFD;

  typedef enum logic {ST_IDLE = 1'b0, ST_STACK = 1'b1} seq_st_e;

  // beat 0: PC, beat 1: PSR, beats 2..7: R0..R3,R12,LR from the frame base
  function automatic logic [4:0] beat_offset(input logic [2:0] k);
    if (k == 3'd0)      return 5'h18;
    else if (k == 3'd1) return 5'h1C;
    else                return {k - 3'd2, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] exc_return(input logic hmode, input logic psp);
    if (hmode)    return RET_HANDLER;
    else if (psp) return RET_THR_PSP;
    else          return RET_THR_MSP;
  endfunction
endpackage

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_seq_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic                            fire_i,
  input  logic [XLEN-1:0]                 pc_i,
  input  logic [XLEN-1:0]                 psr_i,
  input  logic [XLEN-1:0]                 base_i,
  input  logic [GPR_WORDS-1:0][XLEN-1:0]  gpr_i,
  output logic [XLEN-1:0]                 addr_o,
  output logic [XLEN-1:0]                 data_o,
  output logic [XLEN-1:0]                 base_o,
  output logic                            done_o
);
  localparam int unsigned CW = $clog2(FRAME_WORDS + 1);
  localparam int unsigned IW = $clog2(FRAME_WORDS);

  logic [CW-1:0]                cnt_q;
  logic [XLEN-1:0]              pc_q, psr_q, base_q;
  logic [GPR_WORDS-1:0][XLEN-1:0] gpr_q;
  logic [IW-1:0]                idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(FRAME_WORDS);
      pc_q   <= '0;
      psr_q  <= '0;
      base_q <= '0;
      gpr_q  <= '0;
    end else if (load_i) begin
      cnt_q  <= '0;
      pc_q   <= pc_i;
      psr_q  <= psr_i;
      base_q <= base_i;
      gpr_q  <= gpr_i;
    end else if (fire_i && !done_o) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign idx    = cnt_q[IW-1:0];
  assign done_o = (cnt_q == CW'(FRAME_WORDS));
  assign base_o = base_q;
  assign addr_o = base_q + XLEN'(beat_offset(idx));

  always_comb begin
    unique case (idx)
      IW'(0):  data_o = pc_q;
      IW'(1):  data_o = psr_q;
      default: data_o = gpr_q[idx - IW'(2)];
    endcase
  end
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
  import exc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] start_addr_i,
  input  logic            retarget_i,
  input  logic [XLEN-1:0] retarget_addr_i,
  input  logic            abort_i,
  output logic            rd_valid_o,
  output logic [XLEN-1:0] rd_addr_o,
  input  logic            rd_ready_i,
  input  logic [XLEN-1:0] rd_data_i,
  output logic            pending_o,
  output logic [XLEN-1:0] vector_o
);
  logic            need_q;
  logic [XLEN-1:0] addr_q, vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_q <= 1'b0;
      addr_q <= '0;
      vec_q  <= '0;
    end else if (abort_i) begin
      need_q <= 1'b0;
    end else if (start_i) begin
      need_q <= 1'b1;
      addr_q <= start_addr_i;
    end else if (retarget_i) begin
      // a late winner discards any read completing in the same cycle
      need_q <= 1'b1;
      addr_q <= retarget_addr_i;
    end else if (need_q && rd_ready_i) begin
      need_q <= 1'b0;
      vec_q  <= rd_data_i;
    end
  end

  assign rd_valid_o = need_q;
  assign rd_addr_o  = addr_q;
  assign pending_o  = need_q;
  assign vector_o   = vec_q;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned NUM_W = 9
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic [NUM_W-1:0]               req_num_i,
  input  logic [XLEN-1:0]                req_vec_addr_i,
  input  logic                           late_valid_i,
  input  logic [NUM_W-1:0]               late_num_i,
  input  logic [XLEN-1:0]                late_vec_addr_i,
  input  logic                           handler_mode_i,
  input  logic                           psp_active_i,
  input  logic [XLEN-1:0]                msp_i,
  input  logic [XLEN-1:0]                psp_i,
  input  logic [XLEN-1:0]                pc_i,
  input  logic [XLEN-1:0]                psr_i,
  input  logic [GPR_WORDS-1:0][XLEN-1:0] gpr_i,
  output logic                           sw_valid_o,
  output logic [XLEN-1:0]                sw_addr_o,
  output logic [XLEN-1:0]                sw_data_o,
  input  logic                           sw_ready_i,
  input  logic                           sw_err_i,
  input  logic                           sw_mpu_i,
  output logic                           vr_valid_o,
  output logic [XLEN-1:0]                vr_addr_o,
  input  logic                           vr_ready_i,
  input  logic [XLEN-1:0]                vr_rdata_i,
  output logic                           upd_valid_o,
  output logic [NUM_W-1:0]               upd_num_o,
  output logic [XLEN-1:0]                upd_pc_o,
  output logic [XLEN-1:0]                upd_sp_o,
  output logic                           upd_sp_psp_o,
  output logic [XLEN-1:0]                upd_lr_o,
  output logic                           fault_o,
  output logic [7:0]                     bf_status_o,
  output logic [7:0]                     mm_status_o
);
  seq_st_e          st_q, st_d;
  logic [NUM_W-1:0] num_q;
  logic             hmode_q, psp_q;
  logic             accept, stacking, beat_fire, abort, late_take, finish;
  logic             fr_done, vf_pending, use_psp;
  logic [XLEN-1:0]  sp_sel, frame_base;

  assign use_psp    = psp_active_i && !handler_mode_i;
  assign sp_sel     = use_psp ? psp_i : msp_i;
  assign frame_base = sp_sel - XLEN'(FRAME_BYTES);

  assign accept    = (st_q == ST_IDLE) && req_valid_i;
  assign stacking  = (st_q == ST_STACK) && !fr_done;
  assign beat_fire = stacking && sw_ready_i;
  assign abort     = beat_fire && sw_err_i;
  assign late_take = stacking && late_valid_i && !abort;
  assign finish    = (st_q == ST_STACK) && fr_done && !vf_pending;

  always_comb begin
    st_d = st_q;
    if (accept)               st_d = ST_STACK;
    else if (abort || finish) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      num_q   <= '0;
      hmode_q <= 1'b0;
      psp_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        num_q   <= req_num_i;
        hmode_q <= handler_mode_i;
        psp_q   <= use_psp;
      end else if (late_take) begin
        num_q   <= late_num_i;
      end
    end
  end

  exc_frame_gen i_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .fire_i (beat_fire),
    .pc_i   (pc_i),
    .psr_i  (psr_i),
    .base_i (frame_base),
    .gpr_i  (gpr_i),
    .addr_o (sw_addr_o),
    .data_o (sw_data_o),
    .base_o (upd_sp_o),
    .done_o (fr_done)
  );

  exc_vec_fetch i_vfetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (accept),
    .start_addr_i    (req_vec_addr_i),
    .retarget_i      (late_take),
    .retarget_addr_i (late_vec_addr_i),
    .abort_i         (abort),
    .rd_valid_o      (vr_valid_o),
    .rd_addr_o       (vr_addr_o),
    .rd_ready_i      (vr_ready_i),
    .rd_data_i       (vr_rdata_i),
    .pending_o       (vf_pending),
    .vector_o        (upd_pc_o)
  );

  assign req_ready_o  = (st_q == ST_IDLE);
  assign sw_valid_o   = stacking;
  assign upd_valid_o  = finish;
  assign upd_num_o    = num_q;
  assign upd_sp_psp_o = psp_q;
  assign upd_lr_o     = exc_return(hmode_q, psp_q);
  assign fault_o      = abort;

  always_comb begin
    bf_status_o = '0;
    mm_status_o = '0;
    bf_status_o[STK_ERR_BIT] = abort && !sw_mpu_i;
    mm_status_o[STK_ERR_BIT] = abort && sw_mpu_i;
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int unsigned NUM_W = 9
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            sw_valid_o,
  input logic [XLEN-1:0] sw_addr_o,
  input logic [XLEN-1:0] sw_data_o,
  input logic            sw_ready_i,
  input logic            vr_valid_o,
  input logic            vr_ready_i,
  input logic            upd_valid_o,
  input logic [XLEN-1:0] upd_sp_o,
  input logic            upd_sp_psp_o,
  input logic [XLEN-1:0] upd_lr_o,
  input logic            fault_o,
  input logic [7:0]      bf_status_o,
  input logic [7:0]      mm_status_o
);
  p_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o |-> !req_ready_o);

  p_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o |-> ((sw_addr_o - upd_sp_o) < XLEN'(FRAME_BYTES)) && (sw_addr_o[1:0] == 2'b00));

  p_pc_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_valid_o) |-> sw_addr_o == upd_sp_o + XLEN'(32'h18));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_valid_o && !sw_ready_i |=> sw_valid_o && $stable(sw_addr_o) && $stable(sw_data_o));

  p_vr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vr_valid_o && !vr_ready_i && !fault_o |=> vr_valid_o);

  p_upd_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |=> !upd_valid_o && req_ready_o);

  p_lr_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_lr_o == RET_HANDLER) || (upd_lr_o == RET_THR_MSP) || (upd_lr_o == RET_THR_PSP));

  p_lr_psp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o && upd_sp_psp_o |-> upd_lr_o == RET_THR_PSP);

  p_fault_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($countones({bf_status_o, mm_status_o}) == 1) && !upd_valid_o);

  p_fault_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> req_ready_o && !sw_valid_o && !vr_valid_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.NUM_W(NUM_W)) i_chk (.*);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, late_valid = 0, hmode = 0, pspa = 0;
  logic [NUM_W-1:0] req_num = '0, late_num = '0;
  logic [31:0] req_vaddr = '0, late_vaddr = '0, msp = '0, psp = '0, pc = '0, psr = '0;
  logic [5:0][31:0] gpr = '0;
  logic sw_ready = 0, sw_err = 0, sw_mpu = 0, vr_ready = 0;
  logic [31:0] vr_rdata = '0;
  logic req_ready, sw_valid, vr_valid, upd_valid, upd_psp, fault;
  logic [31:0] sw_addr, sw_data, vr_addr, upd_pc, upd_sp, upd_lr;
  logic [NUM_W-1:0] upd_num;
  logic [7:0] bf_st, mm_st;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq #(.NUM_W(NUM_W)) i_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_num_i(req_num), .req_vec_addr_i(req_vaddr),
    .late_valid_i(late_valid), .late_num_i(late_num), .late_vec_addr_i(late_vaddr),
    .handler_mode_i(hmode), .psp_active_i(pspa), .msp_i(msp), .psp_i(psp),
    .pc_i(pc), .psr_i(psr), .gpr_i(gpr),
    .sw_valid_o(sw_valid), .sw_addr_o(sw_addr), .sw_data_o(sw_data),
    .sw_ready_i(sw_ready), .sw_err_i(sw_err), .sw_mpu_i(sw_mpu),
    .vr_valid_o(vr_valid), .vr_addr_o(vr_addr), .vr_ready_i(vr_ready), .vr_rdata_i(vr_rdata),
    .upd_valid_o(upd_valid), .upd_num_o(upd_num), .upd_pc_o(upd_pc), .upd_sp_o(upd_sp),
    .upd_sp_psp_o(upd_psp), .upd_lr_o(upd_lr),
    .fault_o(fault), .bf_status_o(bf_st), .mm_status_o(mm_st)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] vec_data(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} | 32'h1;
  endfunction

  function automatic logic [31:0] exp_off(input int k);
    if (k == 0) return 32'h18;
    if (k == 1) return 32'h1C;
    return 32'((k - 2) * 4);
  endfunction

  function automatic logic [31:0] exp_lr(input bit h, input bit p);
    if (h) return 32'hFFFF_FFF1;
    return p ? 32'hFFFF_FFFD : 32'hFFFF_FFF9;
  endfunction

  // entered and left at a negative edge
  task automatic run_entry(input bit zw, input int vr_hold, input int late_cyc, input int err_beat,
                           input bit err_mpu, input bit h, input bit p, input bit busy_req);
    logic [31:0] s_pc, s_psr, e_base, cur_vaddr, got_pc;
    logic [5:0][31:0] s_gpr;
    logic [NUM_W-1:0] cur_num;
    bit vf_need, aborted, done;
    int k;
    s_pc = $urandom; s_psr = $urandom;
    for (int i = 0; i < 6; i++) s_gpr[i] = $urandom;
    msp = $urandom & ~32'h3; psp = $urandom & ~32'h3;
    hmode = h; pspa = p;
    pc = s_pc; psr = s_psr; gpr = s_gpr;
    req_num = NUM_W'($urandom); req_vaddr = $urandom & ~32'h3;
    late_num = NUM_W'($urandom); late_vaddr = $urandom & ~32'h3;
    e_base = ((p && !h) ? psp : msp) - 32'd32;
    cur_num = req_num; cur_vaddr = req_vaddr; got_pc = '0;
    req_valid = 1;
    #1 chk(req_ready == 1'b1, "R1 ready before request", {31'b0, req_ready}, 1);
    @(posedge clk);
    vf_need = 1; aborted = 0; done = 0; k = 0;
    for (int c = 0; c < 300 && !done && !aborted; c++) begin
      bit swfire, ef, vrfire, ltake, exp_upd;
      @(negedge clk);
      req_valid = busy_req && (c == 2);
      if (c == 0) begin pc = ~s_pc; psr = ~s_psr; gpr = ~s_gpr; msp = ~msp; end
      if (c == 2) req_num = ~cur_num;
      sw_ready = zw ? 1'b1 : ($urandom % 3 != 0);
      sw_err = (k == err_beat);
      sw_mpu = err_mpu;
      vr_ready = (c >= vr_hold) && (zw || ($urandom % 3 != 0));
      vr_rdata = vec_data(vr_addr);
      late_valid = (c == late_cyc);
      #1;
      exp_upd = (k == 8) && !vf_need;
      chk(upd_valid == exp_upd, "R5 update pulse timing", {31'b0, upd_valid}, {31'b0, exp_upd});
      if (exp_upd) begin
        chk(upd_num == cur_num, "R7/R1 exception number", 32'(upd_num), 32'(cur_num));
        chk(upd_pc == got_pc, "R4 handler address", upd_pc, got_pc);
        chk(upd_sp == e_base, "R3 new stack pointer", upd_sp, e_base);
        chk(upd_psp == (p && !h), "R3 stack select", {31'b0, upd_psp}, {31'b0, p && !h});
        chk(upd_lr == exp_lr(h, p), "R6 return code", upd_lr, exp_lr(h, p));
        if (zw && vr_hold == 0 && late_cyc < 0)
          chk(c == 8, "R5 zero-wait latency", 32'(c), 32'd8);
      end
      chk(sw_valid == (k < 8), "R2 write valid", {31'b0, sw_valid}, {31'b0, k < 8});
      if (sw_valid && k < 8) begin
        logic [31:0] ed;
        ed = (k == 0) ? s_pc : (k == 1) ? s_psr : s_gpr[k-2];
        chk(sw_addr == e_base + exp_off(k), "R2 write address", sw_addr, e_base + exp_off(k));
        chk(sw_data == ed, "R2 write data", sw_data, ed);
      end
      chk(vr_valid == vf_need, "R4 read valid", {31'b0, vr_valid}, {31'b0, vf_need});
      if (vf_need) chk(vr_addr == cur_vaddr, "R4 read address", vr_addr, cur_vaddr);
      swfire = sw_valid && sw_ready;
      ef = swfire && sw_err;
      vrfire = vr_valid && vr_ready;
      ltake = late_valid && (k < 8) && !ef;
      chk(fault == ef, "R8 fault pulse", {31'b0, fault}, {31'b0, ef});
      if (ef) begin
        chk(bf_st == (err_mpu ? 8'h00 : 8'h10), "R8 bus status", 32'(bf_st), err_mpu ? 0 : 32'h10);
        chk(mm_st == (err_mpu ? 8'h10 : 8'h00), "R8 mem status", 32'(mm_st), err_mpu ? 32'h10 : 0);
      end
      @(posedge clk);
      if (ltake) begin
        cur_num = late_num; cur_vaddr = late_vaddr; vf_need = 1;
      end else if (vrfire) begin
        vf_need = 0; got_pc = vec_data(cur_vaddr);
      end
      if (ef) aborted = 1;
      else if (swfire) k++;
      if (exp_upd) done = 1;
    end
    @(negedge clk);
    req_valid = 0; late_valid = 0; sw_ready = 0; sw_err = 0; vr_ready = 0;
    #1;
    if (!done && !aborted) chk(0, "R5 no completion", 0, 1);
    chk(req_ready == 1'b1, aborted ? "R8 idle after abort" : "R5 idle after update", {31'b0, req_ready}, 1);
    chk(!sw_valid && !upd_valid, aborted ? "R8 no write or update" : "R5 quiet after update",
        {30'b0, sw_valid, upd_valid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !sw_valid && !vr_valid && !upd_valid && !fault, "R9 reset state",
        {27'b0, req_ready, sw_valid, vr_valid, upd_valid, fault}, 32'h10);
    rst_n = 1;
    @(negedge clk);
    run_entry(1, 0, -1, -1, 0, 0, 0, 0);   // R5 zero wait, main stack, R6
    run_entry(1, 0, -1, -1, 0, 0, 1, 1);   // R3 process stack, R1 busy request
    run_entry(0, 0, -1, -1, 0, 1, 1, 0);   // R3 handler mode forces main stack
    run_entry(1, 0, 3, -1, 0, 0, 0, 0);    // R7 late arrival while stacking
    run_entry(1, 0, 7, -1, 0, 0, 1, 0);    // R7 late arrival on last beat
    run_entry(1, 12, 10, -1, 0, 0, 0, 0);  // R7 late after frame done ignored
    run_entry(0, 0, -1, 3, 0, 0, 0, 0);    // R8 bus error
    run_entry(1, 0, -1, 0, 1, 0, 1, 0);    // R8 protection error on first beat
    run_entry(1, 0, -1, 7, 0, 1, 0, 0);    // R8 error on last beat
    for (int n = 0; n < 40; n++) begin
      int lc, eb;
      lc = ($urandom % 3 == 0) ? int'($urandom % 14) : -1;
      eb = (lc < 0 && $urandom % 5 == 0) ? int'($urandom % 8) : -1;
      run_entry(($urandom % 2) == 1, int'($urandom % 6), lc, eb, ($urandom % 2) == 1,
                ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 4) == 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule